// File: doc/BRIEF.md
# Address-Latched Byte Memory

This block is a synthesizable model of a one-time-programmable byte memory with its own address latch. It suits processors whose low address bits and data bits share one multiplexed bus. While the strobe input is high, the address flows straight through to the array. While the strobe is low, the address seen on the last strobe-high cycle is held. The shared bus lines are then free to carry data, and no external latch is needed.

Two active-low enables, chip enable and output enable, decide whether the byte port drives. Two digital flags replace the high-voltage conditions of a real part:

- A program-supply flag selects the program, verify and inhibit modes.
- An identifier flag selects a fixed two-code signature readout.

Programming can only clear bits. After reset every location reads FFh.

The data port is split into three signals: data in, data out and a drive enable. The three-state buffer belongs to the enclosing chip level. All outputs are registered. The inputs present at one rising clock edge appear on the outputs from the second rising edge after it.

The full-size part uses `ADDR_W` = 15, which gives 32768 bytes. The default is kept smaller so that elaboration stays light.

Top module: `strobed_byte_mem`

## Requirements
- R1: After reset, `data_oe_o` is low, and every location that has never been programmed reads FFh.
- R2: While `strobe_i` is high, each read uses the address present on `addr_i` in that same cycle.
- R3: While `strobe_i` and `prog_pwr_i` are both low, the array address stays at the value of `addr_i` from the last cycle in which the strobe was high. Changes on `addr_i` then have no effect.
- R4: Read mode is `ce_n_i`=0, `oe_n_i`=0 and `prog_pwr_i`=0, without the signature conditions of R10. In read mode, `data_oe_o`=1 and `data_o` is the stored byte, two rising edges after the inputs were sampled.
- R5: Standby is `ce_n_i`=1 with `prog_pwr_i`=0. In standby, `data_oe_o` is 0 whatever the value of `oe_n_i`.
- R6: Output disable is `ce_n_i`=0, `oe_n_i`=1 and `prog_pwr_i`=0. In output disable, `data_oe_o` is 0.
- R7: Program mode is `ce_n_i`=0, `oe_n_i`=0 and `prog_pwr_i`=1. During program mode the port does not drive. When a run of one or more program cycles ends, the byte at the address of the final program cycle becomes the old byte ANDed with the `data_i` of that final cycle.
- R8: Verify mode is `ce_n_i`=1, `oe_n_i`=0 and `prog_pwr_i`=1. In verify mode the stored byte is driven, with the same latency as a read.
- R9: Inhibit mode is `ce_n_i`=1, `oe_n_i`=1 and `prog_pwr_i`=1. In inhibit mode, `data_oe_o` is 0 and no location changes.
- R10: Signature mode is `id_hv_i`=1, `strobe_i`=0, `ce_n_i`=0, `oe_n_i`=0 and `prog_pwr_i`=0. In signature mode the port drives 20h when bit 0 of the array address is 0, and 80h when it is 1. If the strobe is high, the same inputs give a normal read.
- R11: While `prog_pwr_i` is 1, the latch is transparent even when `strobe_i` is low.
- R12: Programming never sets a bit. A second program of the same location with a byte that has ones where the stored byte has zeros leaves those bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address (shared-bus side) |
| strobe_i | input | 1 | Latch control: 1 passes the address through, 0 holds it |
| prog_pwr_i | input | 1 | Program-supply-present flag |
| id_hv_i | input | 1 | Identifier-voltage-present flag |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| data_i | input | DATA_W | Byte to program |
| data_o | output | DATA_W | Registered read data |
| data_oe_o | output | 1 | Registered drive enable for the byte port |

## Verification
The assertions check the port-drive rules on every cycle:

- the quiet outputs in standby, output disable, program and inhibit;
- the driven outputs in read and verify;
- that signature mode yields only one of the two codes;
- that the array address is stable while the latch holds.

Only the bench scenarios can show the following:

- the stored values themselves;
- the AND-only programming result;
- that inhibit leaves memory untouched;
- the code chosen by address bit 0;
- that the latch is forced transparent during programming.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OUT_OFF,
    MD_READ,
    MD_SIGNATURE,
    MD_PROGRAM,
    MD_PROG_IDLE,
    MD_VERIFY,
    MD_INHIBIT
  } mode_e;

  localparam logic [7:0] SIG_MAKER  = 8'h20;
  localparam logic [7:0] SIG_DEVICE = 8'h80;

  function automatic logic port_drives(input mode_e m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_SIGNATURE);
  endfunction

endpackage

// File: rtl/sbm_addr_latch.sv
module sbm_addr_latch #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_i,
  input  logic          force_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] held_q;
  logic          open_w;

  // Transparent when the strobe is high or programming power is present.
  assign open_w = strobe_i | force_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
    end else if (open_w) begin
      held_q <= addr_i;
    end
  end

  assign addr_o = open_w ? addr_i : held_q;

endmodule

// File: rtl/sbm_mode_dec.sv
module sbm_mode_dec
  import sbm_pkg::*;
(
  input  logic  ce_n_i,
  input  logic  oe_n_i,
  input  logic  prog_pwr_i,
  input  logic  id_hv_i,
  input  logic  strobe_i,
  output mode_e mode_o
);

  always_comb begin
    if (prog_pwr_i) begin
      unique case ({ce_n_i, oe_n_i})
        2'b00:   mode_o = MD_PROGRAM;
        2'b01:   mode_o = MD_PROG_IDLE;
        2'b10:   mode_o = MD_VERIFY;
        default: mode_o = MD_INHIBIT;
      endcase
    end else if (ce_n_i) begin
      mode_o = MD_STANDBY;
    end else if (oe_n_i) begin
      mode_o = MD_OUT_OFF;
    end else if (id_hv_i && !strobe_i) begin
      mode_o = MD_SIGNATURE;
    end else begin
      mode_o = MD_READ;
    end
  end

endmodule

// File: rtl/sbm_cell_array.sv
module sbm_cell_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);

  localparam int DEPTH = 1 << AW;

  // Plain storage with no reset, so it maps to block RAM.
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] raw_q;

  // One flag per location: set once the location has been programmed.
  logic [DEPTH-1:0] used_q;
  logic             used_rd_q;
  logic             fwd_q;
  logic [DW-1:0]    fwd_data_q;
  logic             same_w;

  assign same_w = wr_en_i && (wr_addr_i == rd_addr_i);

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
    raw_q <= mem[rd_addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q     <= '0;
      used_rd_q  <= 1'b0;
      fwd_q      <= 1'b0;
      fwd_data_q <= '1;
    end else begin
      if (wr_en_i) begin
        used_q[wr_addr_i] <= 1'b1;
      end
      used_rd_q  <= used_q[rd_addr_i];
      fwd_q      <= same_w;
      fwd_data_q <= wr_data_i;
    end
  end

  always_comb begin
    if (fwd_q) begin
      rd_data_o = fwd_data_q;
    end else if (used_rd_q) begin
      rd_data_o = raw_q;
    end else begin
      rd_data_o = '1;
    end
  end

endmodule

// File: rtl/strobed_byte_mem.sv
module strobed_byte_mem
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              prog_pwr_i,
  input  logic              id_hv_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] pg_addr_q;
  logic [DATA_W-1:0] pg_data_q;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] wr_data;
  logic              pg_arm_q;
  logic              commit;
  logic              a0_q;
  mode_e             mode;
  mode_e             mode_q;

  sbm_addr_latch #(.AW(ADDR_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe_i),
    .force_i  (prog_pwr_i),
    .addr_i   (addr_i),
    .addr_o   (eff_addr)
  );

  sbm_mode_dec u_dec (
    .ce_n_i     (ce_n_i),
    .oe_n_i     (oe_n_i),
    .prog_pwr_i (prog_pwr_i),
    .id_hv_i    (id_hv_i),
    .strobe_i   (strobe_i),
    .mode_o     (mode)
  );

  // Write when a run of program cycles ends. rd_data then holds the old
  // byte at pg_addr_q, which was read on the last program cycle.
  assign commit  = pg_arm_q && (mode != MD_PROGRAM);
  assign wr_data = rd_data & pg_data_q;

  sbm_cell_array #(.AW(ADDR_W), .DW(DATA_W)) u_arr (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_i (eff_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (commit),
    .wr_addr_i (pg_addr_q),
    .wr_data_i (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_arm_q  <= 1'b0;
      pg_addr_q <= '0;
      pg_data_q <= '1;
    end else if (mode == MD_PROGRAM) begin
      pg_arm_q  <= 1'b1;
      pg_addr_q <= eff_addr;
      pg_data_q <= data_i;
    end else begin
      pg_arm_q  <= 1'b0;
    end
  end

  // Stage 1 runs beside the array read; stage 2 is the registered port.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MD_STANDBY;
      a0_q      <= 1'b0;
      data_o    <= '0;
      data_oe_o <= 1'b0;
    end else begin
      mode_q    <= mode;
      a0_q      <= eff_addr[0];
      data_oe_o <= port_drives(mode_q);
      if (mode_q == MD_SIGNATURE) begin
        data_o <= a0_q ? DATA_W'(SIG_DEVICE) : DATA_W'(SIG_MAKER);
      end else if (port_drives(mode_q)) begin
        data_o <= rd_data;
      end else begin
        data_o <= '0;
      end
    end
  end

endmodule

// File: rtl/strobed_byte_mem_chk.sv
module strobed_byte_mem_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_n,
  input logic          oe_n,
  input logic          pwr,
  input logic          idv,
  input logic          stb,
  input logic [AW-1:0] eff_addr,
  input logic [DW-1:0] dout,
  input logic          doe
);

  logic [1:0] since_q;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
    end else if (since_q != 2'd2) begin
      since_q <= since_q + 2'd1;
    end
  end

  assign warm = (since_q == 2'd2);

  // R1: the port stays quiet while the pipeline fills after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    !warm |-> !doe);

  // R4
  a_r4_read_drives: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!ce_n && !oe_n && !pwr, 2)) |-> doe);

  // R5
  a_r5_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(ce_n && !pwr, 2)) |-> !doe);

  // R6
  a_r6_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!ce_n && oe_n && !pwr, 2)) |-> !doe);

  // R7
  a_r7_program_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!ce_n && pwr, 2)) |-> !doe);

  // R8
  a_r8_verify_drives: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(ce_n && !oe_n && pwr, 2)) |-> doe);

  // R9
  a_r9_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(ce_n && oe_n && pwr, 2)) |-> !doe);

  // R10
  a_r10_sig_code: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!ce_n && !oe_n && !pwr && idv && !stb, 2))
      |-> (doe && (dout == DW'(8'h20) || dout == DW'(8'h80))));

  // R3
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (since_q != 2'd0 && !stb && !pwr && $past(!stb && !pwr)) |-> $stable(eff_addr));

endmodule

bind strobed_byte_mem strobed_byte_mem_chk #(.AW(ADDR_W), .DW(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n_i),
  .oe_n     (oe_n_i),
  .pwr      (prog_pwr_i),
  .idv      (id_hv_i),
  .stb      (strobe_i),
  .eff_addr (eff_addr),
  .dout     (data_o),
  .doe      (data_oe_o)
);

// File: tb/strobed_byte_mem_tb_top.sv
`timescale 1ns/1ps
module strobed_byte_mem_tb_top;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          stb = 1'b1;
  logic          pwr = 1'b0;
  logic          idv = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          doe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 0;

  typedef struct {
    int         due;
    bit         oe;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  strobed_byte_mem #(.ADDR_W(AW), .DATA_W(8)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr),
    .strobe_i   (stb),
    .prog_pwr_i (pwr),
    .id_hv_i    (idv),
    .ce_n_i     (ce_n),
    .oe_n_i     (oe_n),
    .data_i     (din),
    .data_o     (dout),
    .data_oe_o  (doe)
  );

  // Monitor: pops the items that fall due and compares them with the port.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (doe !== e.oe || (e.oe && dout !== e.d)) begin
        n_fail++;
        $display("FAIL %s: oe=%0b data=%02h, expected oe=%0b data=%02h",
                 e.tag, doe, dout, e.oe, e.d);
      end
    end
  end

  // Driver: holds one set of inputs for one cycle. When asked, it queues the
  // expected port state, which is due two rising edges later.
  task automatic step(input bit c, input bit o, input bit p, input bit i,
                      input bit s, input logic [AW-1:0] a, input logic [7:0] dv,
                      input bit chk, input bit eoe, input logic [7:0] ed,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = c; oe_n = o; pwr = p; idv = i; stb = s; addr = a; din = dv;
    if (chk) begin
      e.due = cyc + 2; e.oe = eoe; e.d = ed; e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic rd(input bit s, input logic [AW-1:0] a, input logic [7:0] ed,
                    input string tag);
    step(0, 0, 0, 0, s, a, 8'h00, 1, 1, ed, tag);
  endtask

  task automatic program_byte(input bit s, input logic [AW-1:0] a, input logic [7:0] dv);
    step(0, 0, 1, 0, s, a, dv, 1, 0, 8'h00, "R7");
    step(0, 1, 1, 0, s, a, dv, 0, 0, 8'h00, "");
  endtask

  task automatic verify(input logic [AW-1:0] a, input logic [7:0] ed, input string tag);
    step(1, 0, 1, 0, 1, a, 8'h00, 1, 1, ed, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: quiet port after reset, erased contents
    step(1, 1, 0, 0, 1, 10'd0, 8'h00, 1, 0, 8'h00, "R1");
    rd(1, 10'd5, 8'hFF, "R1");
    rd(1, 10'h3FF, 8'hFF, "R1");
    // R7 / R8 / R4: program, then verify and read back
    program_byte(1, 10'd5, 8'h3C);
    verify(10'd5, 8'h3C, "R8");
    rd(1, 10'd5, 8'h3C, "R4");
    // R12: a second program only clears bits
    program_byte(1, 10'd5, 8'hF0);
    verify(10'd5, 8'h30, "R12");
    // R11: the latch is loaded with 5, then programming with the strobe low uses addr_i
    rd(1, 10'd5, 8'h30, "R11");
    program_byte(0, 10'h2AA, 8'hA5);
    verify(10'h2AA, 8'hA5, "R11");
    rd(1, 10'd5, 8'h30, "R11");
    // R2: the address follows addr_i every cycle
    rd(1, 10'd7, 8'hFF, "R2");
    rd(1, 10'd5, 8'h30, "R2");
    rd(1, 10'h2AA, 8'hA5, "R2");
    // R3: the latch holds while the strobe is low
    rd(0, 10'd5, 8'hA5, "R3");
    rd(0, 10'd7, 8'hA5, "R3");
    // R5: standby, with output enable both ways
    step(1, 0, 0, 0, 1, 10'd5, 8'h00, 1, 0, 8'h00, "R5");
    step(1, 1, 0, 0, 1, 10'd5, 8'h00, 1, 0, 8'h00, "R5");
    // R6: output disable
    step(0, 1, 0, 0, 1, 10'd5, 8'h00, 1, 0, 8'h00, "R6");
    // R9: inhibit drives nothing and writes nothing
    step(1, 1, 1, 0, 1, 10'd5, 8'h00, 1, 0, 8'h00, "R9");
    step(1, 1, 1, 0, 1, 10'd5, 8'h00, 1, 0, 8'h00, "R9");
    verify(10'd5, 8'h30, "R9");
    // R10: signature codes selected by bit 0 of the latched address
    rd(1, 10'h2AA, 8'hA5, "R10");
    step(0, 0, 0, 1, 0, 10'h3FF, 8'h00, 1, 1, 8'h20, "R10");
    rd(1, 10'h101, 8'hFF, "R10");
    step(0, 0, 0, 1, 0, 10'h100, 8'h00, 1, 1, 8'h80, "R10");
    step(0, 0, 0, 1, 1, 10'd5, 8'h00, 1, 1, 8'h30, "R10");
    step(1, 1, 0, 0, 1, 10'd0, 8'h00, 0, 0, 8'h00, "");
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule